// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block predicts branches for an instruction fetch stage. Fetch presents an address on the lookup port. In the same cycle the block reports three things: whether that address is a known branch, the destination it jumped to the last time it was taken, and a predicted direction. The prediction comes from a two-bit saturating history counter.

Once a branch has executed, the pipeline sends its address, its real outcome and its real destination on the update port. The block then trains the matching entry. If the branch was taken and has no entry, the block allocates one.

Storage is 64 sets of four ways, 256 entries in all, held in plain register arrays. Within a set, a small binary tree of pseudo-LRU bits picks the way to replace once every way is valid.

Top module: `btb_predictor`

## Requirements
- R1: Reset clears every valid bit and every replacement tree, so after reset every lookup misses.
- R2: The set is address bits [7:2]. The tag is address bits [31:8] together with bits [1:0]. A lookup hits only when a valid way in its set holds an equal tag, so an address that differs in any bit outside [7:2] misses.
- R3: On a hit, the lookup returns the stored target, and predicts taken exactly when the counter is 2 or 3. On a miss, the lookup returns target 0 and predicts not taken.
- R4: A taken update that hits an entry raises its counter by one, stopping at 3, and replaces its stored target with the resolved target.
- R5: A not-taken update that hits an entry lowers its counter by one, stopping at 0, and keeps its stored target.
- R6: A taken update that misses writes a new entry with counter 2 and the resolved target. It goes into the lowest-numbered invalid way of the set.
- R7: When all four ways are valid, a taken miss replaces the way named by the set's tree. The tree has a root bit and a pair bit for ways 0/1 and one for ways 2/3; a 0 bit selects the lower side. Every update that hits or allocates marks its way as most recently used by pointing the bits on its path away from it. The bits start at 0.
- R8: A not-taken update that misses changes no entry.
- R9: A lookup in the same cycle as an update returns the contents from before that update. The update becomes visible in the next cycle.
- R10: While the update-valid input is low, the update inputs change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr | input | 32 | Fetch address to look up |
| lk_hit | output | 1 | The address matches a valid entry |
| lk_target | output | 32 | Predicted destination (0 on a miss) |
| lk_taken | output | 1 | Predicted direction |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_addr | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |
| up_target | input | 32 | Actual destination of the resolved branch |

## Verification
Several properties are checked on every clock:
- a predicted-taken result always comes with a hit;
- a miss always reports target zero;
- at most one way matches a lookup;
- after a taken update, the branch hits in the next cycle with the new target;
- a not-taken miss leaves its address missing;
- a not-taken hit keeps its target.

Some behaviours span many cycles and only the bench's scenarios show them: the counter saturating at both ends, the exact victim order of the replacement tree, the pre-update view seen by a lookup in the same cycle, and the effect of a reset in the middle of a run. The bench covers these with directed sequences and a long random run over a few crowded sets, all compared against a behavioural model.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef logic [1:0] btb_ctr_t;

  localparam btb_ctr_t BTB_CTR_ALLOC = 2'd2;
  localparam btb_ctr_t BTB_CTR_MAX   = 2'd3;
  localparam btb_ctr_t BTB_CTR_MIN   = 2'd0;

  // Saturating history counter step.
  function automatic btb_ctr_t btb_ctr_next(input btb_ctr_t c, input logic taken);
    btb_ctr_t n;
    if (taken) n = (c == BTB_CTR_MAX) ? c : c + 2'd1;
    else       n = (c == BTB_CTR_MIN) ? c : c - 2'd1;
    return n;
  endfunction

  // Upper half of the counter range predicts taken.
  function automatic logic btb_ctr_predict(input btb_ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/btb_way_match.sv
module btb_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 26,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  input  logic [TAG_W-1:0]            key,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        hit_any,
  output logic [WAY_W-1:0]            hit_idx
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid[w] && (tags[w] == key);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_idx = WAY_W'(w);
    end
  end
endmodule

// File: rtl/btb_plru_bank.sv
module btb_plru_bank #(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] set_sel,
  output logic [WAY_W-1:0] victim,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way
);
  logic [NODES-1:0] tree_q [SETS];

  // Walk from the root: a 0 bit steers to the lower child.
  function automatic logic [WAY_W-1:0] tree_victim(input logic [NODES-1:0] t);
    int node;
    node = 0;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      node = 2 * node + 1 + int'(t[node]);
    end
    return WAY_W'(node - NODES);
  endfunction

  // Point every node on the path away from the touched leaf.
  function automatic logic [NODES-1:0] tree_touch(input logic [NODES-1:0] t,
                                                  input logic [WAY_W-1:0] w);
    logic [NODES-1:0] n;
    int idx;
    int par;
    n   = t;
    idx = int'(w) + NODES;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      par    = (idx - 1) / 2;
      n[par] = (idx == 2 * par + 1);
      idx    = par;
    end
    return n;
  endfunction

  assign victim = tree_victim(tree_q[set_sel]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_en) begin
      tree_q[set_sel] <= tree_touch(tree_q[set_sel], touch_way);
    end
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SETS     = 64,
  parameter int WAYS     = 4,
  parameter int OFFSET_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_target,
  output logic              lk_taken,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken,
  input  logic [ADDR_W-1:0] up_target
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFFSET_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFFSET_W+IDX_W], a[OFFSET_W-1:0]};
  endfunction

  // Storage
  logic [WAYS-1:0]                valid_q  [SETS];
  logic [WAYS-1:0][TAG_W-1:0]     tag_q    [SETS];
  logic [WAYS-1:0][ADDR_W-1:0]    target_q [SETS];
  logic [WAYS-1:0][1:0]           ctr_q    [SETS];

  // Lookup side
  logic [IDX_W-1:0]               lk_set;
  logic [TAG_W-1:0]               lk_tag;
  logic [WAYS-1:0]                lk_hit_vec;
  logic [WAY_W-1:0]               lk_idx;
  logic [WAYS-1:0][ADDR_W-1:0]    lk_tgt_row;
  logic [WAYS-1:0][1:0]           lk_ctr_row;

  assign lk_set     = set_of(lk_addr);
  assign lk_tag     = tag_of(lk_addr);
  assign lk_tgt_row = target_q[lk_set];
  assign lk_ctr_row = ctr_q[lk_set];

  btb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .valid   (valid_q[lk_set]),
    .tags    (tag_q[lk_set]),
    .key     (lk_tag),
    .hit_vec (lk_hit_vec),
    .hit_any (lk_hit),
    .hit_idx (lk_idx)
  );

  always_comb begin
    lk_target = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_hit_vec[w]) lk_target = lk_target | lk_tgt_row[w];
    end
  end

  assign lk_taken = lk_hit && btb_ctr_predict(lk_ctr_row[lk_idx]);

  // Update side
  logic [IDX_W-1:0]               up_set;
  logic [TAG_W-1:0]               up_tag;
  logic [WAYS-1:0]                up_valid_row;
  logic [WAYS-1:0][1:0]           up_ctr_row;
  logic [WAYS-1:0]                upd_hit_vec;
  logic                           upd_hit;
  logic [WAY_W-1:0]               upd_idx;
  logic                           free_any;
  logic [WAY_W-1:0]               free_way;
  logic [WAY_W-1:0]               plru_victim;
  logic [WAY_W-1:0]               alloc_way;
  logic                           alloc_en;
  logic                           wr_en;
  logic [WAY_W-1:0]               wr_way;
  btb_ctr_t                       wr_ctr;

  assign up_set       = set_of(up_addr);
  assign up_tag       = tag_of(up_addr);
  assign up_valid_row = valid_q[up_set];
  assign up_ctr_row   = ctr_q[up_set];

  btb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_up_match (
    .valid   (up_valid_row),
    .tags    (tag_q[up_set]),
    .key     (up_tag),
    .hit_vec (upd_hit_vec),
    .hit_any (upd_hit),
    .hit_idx (upd_idx)
  );

  // Lowest-numbered invalid way wins.
  always_comb begin
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!up_valid_row[w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  btb_plru_bank #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_sel   (up_set),
    .victim    (plru_victim),
    .touch_en  (wr_en),
    .touch_way (wr_way)
  );

  assign alloc_way = free_any ? free_way : plru_victim;
  assign alloc_en  = up_valid && up_taken && !upd_hit;
  assign wr_en     = (up_valid && upd_hit) || alloc_en;
  assign wr_way    = upd_hit ? upd_idx : alloc_way;
  assign wr_ctr    = upd_hit ? btb_ctr_next(up_ctr_row[upd_idx], up_taken) : BTB_CTR_ALLOC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (wr_en) begin
      valid_q[up_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && wr_en) begin
      tag_q[up_set][wr_way] <= up_tag;
      ctr_q[up_set][wr_way] <= wr_ctr;
      if (up_taken) target_q[up_set][wr_way] <= up_target;
    end
  end
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_hit,
  input logic [ADDR_W-1:0] lk_target,
  input logic              lk_taken,
  input logic              up_valid,
  input logic [ADDR_W-1:0] up_addr,
  input logic              up_taken,
  input logic [ADDR_W-1:0] up_target,
  input logic [WAYS-1:0]   lk_hit_vec,
  input logic              upd_hit
);
  a_r3_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_taken |-> lk_hit);

  a_r3_miss_target_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_target == '0));

  a_r2_single_way: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec));

  // R4 / R6: a taken branch is present with its new target one cycle later.
  a_r4_taken_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken) |=>
      ((lk_addr != $past(up_addr)) || (lk_hit && lk_target == $past(up_target))));

  a_r8_no_alloc_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken && !upd_hit) |=>
      ((lk_addr != $past(up_addr)) || !lk_hit));

  a_r5_target_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken && upd_hit && lk_addr == up_addr) |=>
      ((lk_addr != $past(up_addr)) || (lk_target == $past(lk_target))));
endmodule

bind btb_predictor btb_predictor_chk #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_addr    (lk_addr),
  .lk_hit     (lk_hit),
  .lk_target  (lk_target),
  .lk_taken   (lk_taken),
  .up_valid   (up_valid),
  .up_addr    (up_addr),
  .up_taken   (up_taken),
  .up_target  (up_target),
  .lk_hit_vec (lk_hit_vec),
  .upd_hit    (upd_hit)
);

// File: tb/btb_predictor_test.sv
module btb_predictor_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_hit;
  logic [31:0] lk_target;
  logic        lk_taken;
  logic        up_valid = 1'b0;
  logic [31:0] up_addr = '0;
  logic        up_taken = 1'b0;
  logic [31:0] up_target = '0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  btb_predictor uut (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_target(lk_target), .lk_taken(lk_taken), .up_valid(up_valid),
    .up_addr(up_addr), .up_taken(up_taken), .up_target(up_target)
  );

  // Behavioural reference: full-address match, integer counters, 3-bit trees.
  bit          m_valid [64][4];
  logic [31:0] m_addr  [64][4];
  logic [31:0] m_tgt   [64][4];
  int          m_ctr   [64][4];
  bit   [2:0]  m_tree  [64];  // [0] root, [1] ways 0/1, [2] ways 2/3

  function automatic int set_idx(input logic [31:0] a);
    return int'((a >> 2) & 32'h3f);
  endfunction

  function automatic logic [31:0] mk(input int tag, input int set);
    return (32'(tag) << 8) | (32'(set) << 2);
  endfunction

  task automatic model_clear();
    for (int s = 0; s < 64; s++) begin
      m_tree[s] = 3'b000;
      for (int w = 0; w < 4; w++) m_valid[s][w] = 0;
    end
  endtask

  task automatic model_lookup(input logic [31:0] a, output bit h,
                              output logic [31:0] t, output bit tk);
    int s;
    s = set_idx(a);
    h = 0; t = '0; tk = 0;
    for (int w = 0; w < 4; w++) begin
      if (m_valid[s][w] && m_addr[s][w] == a) begin
        h = 1; t = m_tgt[s][w]; tk = (m_ctr[s][w] >= 2);
      end
    end
  endtask

  task automatic model_touch(input int s, input int w);
    case (w)
      0: begin m_tree[s][0] = 1; m_tree[s][1] = 1; end
      1: begin m_tree[s][0] = 1; m_tree[s][1] = 0; end
      2: begin m_tree[s][0] = 0; m_tree[s][2] = 1; end
      default: begin m_tree[s][0] = 0; m_tree[s][2] = 0; end
    endcase
  endtask

  task automatic model_update(input logic [31:0] a, input bit tk, input logic [31:0] tg);
    int s;
    int hw;
    int vw;
    s = set_idx(a);
    hw = -1;
    for (int w = 0; w < 4; w++)
      if (m_valid[s][w] && m_addr[s][w] == a) hw = w;
    if (hw >= 0) begin
      if (tk) begin
        if (m_ctr[s][hw] < 3) m_ctr[s][hw]++;
        m_tgt[s][hw] = tg;
      end else if (m_ctr[s][hw] > 0) m_ctr[s][hw]--;
      model_touch(s, hw);
    end else if (tk) begin
      vw = -1;
      for (int w = 3; w >= 0; w--) if (!m_valid[s][w]) vw = w;
      if (vw < 0) begin
        if (m_tree[s][0] == 0) vw = m_tree[s][1] ? 1 : 0;
        else                   vw = m_tree[s][2] ? 3 : 2;
      end
      m_valid[s][vw] = 1; m_addr[s][vw] = a; m_tgt[s][vw] = tg; m_ctr[s][vw] = 2;
      model_touch(s, vw);
    end
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // One cycle: drive at the falling edge, compare before the rising edge.
  task automatic step(input string req, input logic [31:0] la, input bit uv,
                      input logic [31:0] ua, input bit ut, input logic [31:0] utg);
    bit h;
    bit tk;
    logic [31:0] t;
    @(negedge clk);
    lk_addr = la; up_valid = uv; up_addr = ua; up_taken = ut; up_target = utg;
    #1;
    model_lookup(la, h, t, tk);
    checks++;
    if (lk_hit !== h || lk_target !== t || lk_taken !== tk) begin
      failures++;
      $display("FAIL %s lookup %h: actual hit=%b tgt=%h tk=%b expected hit=%b tgt=%h tk=%b",
               req, la, lk_hit, lk_target, lk_taken, h, t, tk);
    end
    if (uv) model_update(ua, ut, utg);
  endtask

  task automatic look(input string req, input logic [31:0] la);
    step(req, la, 0, '0, 0, '0);
  endtask

  task automatic train(input string req, input logic [31:0] ua, input bit ut,
                       input logic [31:0] utg);
    step(req, ua, 1, ua, ut, utg);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; up_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_clear();
  endtask

  initial begin
    logic [31:0] a;
    logic [31:0] b;
    model_clear();
    do_reset();

    // R1: empty after reset
    look("R1", mk(1, 3));
    chk("R1", "hit after reset", 32'(lk_hit), 0);

    // R8: not-taken miss allocates nothing
    train("R8", mk(1, 3), 0, 32'h0);
    look("R8", mk(1, 3));
    chk("R8", "hit after not-taken miss", 32'(lk_hit), 0);

    // R6 + R9: allocation, invisible in the same cycle
    train("R9", mk(1, 3), 1, 32'h1000);
    chk("R9", "same-cycle hit", 32'(lk_hit), 0);
    look("R6", mk(1, 3));
    chk("R6", "target", lk_target, 32'h1000);
    chk("R6", "taken (ctr 2)", 32'(lk_taken), 1);

    // R4: taken hits raise and saturate, target replaced
    train("R4", mk(1, 3), 1, 32'h2000);
    train("R4", mk(1, 3), 1, 32'h2000);
    train("R5", mk(1, 3), 0, 32'h9999);
    train("R5", mk(1, 3), 0, 32'h9999);
    look("R5", mk(1, 3));
    chk("R5", "not taken at ctr 1", 32'(lk_taken), 0);
    chk("R5", "target kept", lk_target, 32'h2000);
    train("R5", mk(1, 3), 0, 32'h9999);
    train("R5", mk(1, 3), 0, 32'h9999);
    train("R4", mk(1, 3), 1, 32'h3000);
    look("R4", mk(1, 3));
    chk("R4", "floor then +1 stays not taken", 32'(lk_taken), 0);
    chk("R4", "target replaced", lk_target, 32'h3000);

    // R2: index and tag fields
    look("R2", mk(2, 3));
    chk("R2", "other tag", 32'(lk_hit), 0);
    look("R2", mk(1, 4));
    chk("R2", "other set", 32'(lk_hit), 0);
    look("R2", mk(1, 3) | 32'h1);
    chk("R2", "offset bits", 32'(lk_hit), 0);

    // R7: fill set 9, then replace through the tree
    for (int t = 1; t <= 4; t++) train("R6", mk(t, 9), 1, 32'(t * 16));
    train("R7", mk(5, 9), 1, 32'h50);
    look("R7", mk(1, 9));
    chk("R7", "way 0 evicted", 32'(lk_hit), 0);
    look("R7", mk(5, 9));
    chk("R7", "new entry", lk_target, 32'h50);
    train("R7", mk(2, 9), 0, 32'h0);
    train("R7", mk(6, 9), 1, 32'h60);
    look("R7", mk(3, 9));
    chk("R7", "way 2 evicted", 32'(lk_hit), 0);
    look("R7", mk(2, 9));
    chk("R7", "way 1 kept", 32'(lk_hit), 1);

    // R10: update inputs ignored while invalid
    step("R10", mk(7, 9), 0, mk(7, 9), 1, 32'h70);
    look("R10", mk(7, 9));
    chk("R10", "no allocation", 32'(lk_hit), 0);
    look("R10", mk(2, 9));
    chk("R10", "existing untouched", lk_target, 32'h20);

    // Random traffic over a few crowded sets
    for (int i = 0; i < 4000; i++) begin
      a = mk(int'($urandom_range(0, 6)), ($urandom_range(0, 1) == 0) ? 5 : 11);
      b = mk(int'($urandom_range(0, 6)), ($urandom_range(0, 1) == 0) ? 5 : 11);
      if ($urandom_range(0, 3) == 0) a = b;
      step("R7", a, $urandom_range(0, 3) != 0, b, $urandom_range(0, 1) == 1,
           $urandom);
    end

    // R1: reset in the middle of a run
    train("R1", mk(3, 20), 1, 32'h77);
    do_reset();
    look("R1", mk(3, 20));
    chk("R1", "hit after mid-run reset", 32'(lk_hit), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule